// File: doc/BRIEF.md
# I2C Master Byte Engine

This block drives an I2C bus as the only kind of participant it knows how to be: a controller. Software, or a small sequencer, steers it one bus step at a time. Each step is a start condition, a repeated start, an address byte, a data byte sent or received, or a stop condition. It is requested through a control write. After every step except a stop, the engine raises an event flag, publishes a fixed status code and then holds SCL low. The bus stays frozen until the flag is cleared by the next control write.

Both bus lines are open drain. The engine only ever pulls a line low (`*_oe_o` high) and reads the resolved level back. A target that holds SCL low delays the engine. When the engine releases SDA to send a 1 but reads a 0, it has lost arbitration. It then lets go of both lines and reports code 0x38.

The bit rate comes from an 8-bit divider and a 2-bit power-of-four prescaler. A quarter-period phase counter places the setup, clock-high and sampling points.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status reads 0xF8, the event flag is 0, the data register is 0 and neither line is pulled.
- R2: While a byte is in flight, the time between SCL rising edges is 16 + 2·DIV·4^PS clock cycles. The divider (DIV) is written with select 2 and the prescaler (PS) with select 3, bits 1:0.
- R3: Status bits 2:0 always read {0, PS}. Bits 7:3 hold the code of the pending event, and read 5'b11111 (0xF8 with PS=0) whenever no event is pending.
- R4: A control write (select 0) with clear-flag bit 0 = 1, start bit 1 = 1, stop bit 2 = 0 and enable bit 4 = 1 puts SDA low while SCL is high. It then reports 0x08 if the bus was free, or 0x10 if the engine already owned it.
- R5: A clear-flag write while the engine holds the bus after a start sends the data register (select 1) MSB first. Bit 0 of that byte selects read (1) or write (0). The engine reports 0x18 or 0x20 for a write address acknowledged or not, and 0x40 or 0x48 for a read address acknowledged or not.
- R6: After a write address, each clear-flag write sends the data register MSB first. It reports 0x28 if the target acknowledges and 0x30 if it does not.
- R7: After a read address, each clear-flag write receives a byte, MSB first. The byte is placed in the data register before the flag rises. The engine then drives ACK if ack-enable (control bit 3) is 1, reporting 0x50, or leaves SDA released, reporting 0x58.
- R8: While the event flag is set, SCL stays low and neither line changes until the next control write.
- R9: A clear-flag write with the stop bit set, while the engine owns the bus, raises SDA while SCL is high. The stop indication (`stop_busy_o`) is high during the stop and clears itself at the end. The event flag stays 0, status returns to 0xF8 and both lines are released. If start and stop are requested together, only the stop is performed.
- R10: If SDA reads low during an address or transmitted data bit that the engine left released, the engine releases both lines at once and reports 0x38 with the flag set. It stops owning the bus, so the next start reports 0x08.
- R11: While a target holds SCL low, the engine waits. No sample and no quarter advance happen until SCL reads high.
- R12: A control write with enable (bit 4) = 0 releases both lines, clears the flag and ownership, and returns status to 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 data, 2 divider, 3 prescaler |
| wr_data | input | 8 | Write data |
| status_o | output | 8 | Event code in 7:3, prescaler in 1:0 |
| data_o | output | 8 | Data register (last byte written or received) |
| evt_o | output | 1 | Event flag; the bus is frozen while high |
| stop_busy_o | output | 1 | High while a stop condition is being placed |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |

## Verification
Two pairs of things can land in the same cycle or in the same request. First, a stop request and a start request can share one control write. The bench writes both bits together and checks three results: exactly one stop condition appears on the line, no start condition follows, and no event is raised. Second, the quarter-end edge that samples a transmitted bit is also the edge that detects arbitration loss. The bench model pulls SDA low under a released address bit and checks that the sample edge yields 0x38 with both lines released, rather than a normal address code. The same sampling edge is also delayed by a target holding SCL low.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BYTE, ST_STOP, ST_HOLD} eng_state_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_DIV  = 2'd2;
  localparam logic [1:0] SEL_PS   = 2'd3;

  localparam int CB_CLR = 0;
  localparam int CB_STA = 1;
  localparam int CB_STO = 2;
  localparam int CB_ACK = 3;
  localparam int CB_EN  = 4;

  // event codes, status bits 7:3
  localparam logic [4:0] EV_START   = 5'h01;
  localparam logic [4:0] EV_RSTART  = 5'h02;
  localparam logic [4:0] EV_AW_ACK  = 5'h03;
  localparam logic [4:0] EV_AW_NACK = 5'h04;
  localparam logic [4:0] EV_DW_ACK  = 5'h05;
  localparam logic [4:0] EV_DW_NACK = 5'h06;
  localparam logic [4:0] EV_ARB     = 5'h07;
  localparam logic [4:0] EV_AR_ACK  = 5'h08;
  localparam logic [4:0] EV_AR_NACK = 5'h09;
  localparam logic [4:0] EV_DR_ACK  = 5'h0A;
  localparam logic [4:0] EV_DR_NACK = 5'h0B;
  localparam logic [4:0] EV_NONE    = 5'h1F;
endpackage

// File: rtl/i2c_bm_quarter.sv
module i2c_bm_quarter #(
  parameter int DIV_W = 8,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  input  logic [PS_W-1:0]  ps,
  output logic [1:0]       q,
  output logic             q_end
);
  localparam int MAX_SH = 2 * ((1 << PS_W) - 1);
  localparam int HALF_W = DIV_W + MAX_SH + 1;

  logic [HALF_W-1:0] half, lo, hi, len, cnt;

  always_comb begin
    half  = HALF_W'(8) + (HALF_W'(div) << {ps, 1'b0});
    lo    = half >> 1;
    hi    = half - lo;
    len   = q[0] ? hi : lo;
    q_end = run && !hold && (cnt == len - HALF_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (!hold) begin
      if (q_end) begin
        cnt <= '0;
        q   <= q + 2'd1;
      end else begin
        cnt <= cnt + HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/i2c_bm_shreg.sv
module i2c_bm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)        val <= '0;
    else if (load)  val <= load_val;
    else if (shift) val <= {val[W-2:0], sin};
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PS_W  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] status_o,
  output logic [7:0] data_o,
  output logic       evt_o,
  output logic       stop_busy_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int BITS = 8;
  localparam int BC_W = $clog2(BITS + 1);

  eng_state_t        state;
  logic [DIV_W-1:0]  div_q;
  logic [PS_W-1:0]   ps_q;
  logic [7:0]        dreg;
  logic [4:0]        code_q;
  logic              evt_q, owned_q, rx_mode_q, first_q, rd_q, ack_en_q, ack_s;
  logic              scl_oe_q, sda_oe_q;
  logic [BC_W-1:0]   bitcnt;

  logic       ctrl_wr, go, run, hold, q_end, tx_now, sample, lost;
  logic [1:0] q;
  logic [BITS-1:0] sh_val;

  always_comb begin
    ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    go      = ctrl_wr && wr_data[CB_CLR] && wr_data[CB_EN] &&
              (state == ST_IDLE || state == ST_HOLD);
    run     = (state == ST_START) || (state == ST_BYTE) || (state == ST_STOP);
    hold    = (q == 2'd1) && !scl_oe_q && !scl_i;
    tx_now  = first_q || !rx_mode_q;
    sample  = (state == ST_BYTE) && q_end && (q == 2'd1);
    lost    = sample && (bitcnt < BC_W'(BITS)) && tx_now && !sda_oe_q && !sda_i;
  end

  i2c_bm_quarter #(.DIV_W(DIV_W), .PS_W(PS_W)) u_quarter (
    .clk(clk), .rst(rst), .run(run), .hold(hold),
    .div(div_q), .ps(ps_q), .q(q), .q_end(q_end)
  );

  i2c_bm_shreg #(.W(BITS)) u_shreg (
    .clk(clk), .rst(rst),
    .load(go && state == ST_HOLD), .load_val(dreg),
    .shift(sample && bitcnt < BC_W'(BITS)), .sin(sda_i),
    .val(sh_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      div_q     <= '0;
      ps_q      <= '0;
      dreg      <= '0;
      code_q    <= EV_NONE;
      evt_q     <= 1'b0;
      owned_q   <= 1'b0;
      rx_mode_q <= 1'b0;
      first_q   <= 1'b0;
      rd_q      <= 1'b0;
      ack_en_q  <= 1'b0;
      ack_s     <= 1'b1;
      scl_oe_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      bitcnt    <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_DIV)  div_q <= wr_data[DIV_W-1:0];
      if (wr_en && wr_sel == SEL_PS)   ps_q  <= wr_data[PS_W-1:0];
      if (wr_en && wr_sel == SEL_DATA) dreg  <= wr_data;
      if (ctrl_wr) ack_en_q <= wr_data[CB_ACK];

      if (ctrl_wr && !wr_data[CB_EN]) begin
        state    <= ST_IDLE;
        scl_oe_q <= 1'b0;
        sda_oe_q <= 1'b0;
        evt_q    <= 1'b0;
        owned_q  <= 1'b0;
        code_q   <= EV_NONE;
      end else if (go) begin
        evt_q <= 1'b0;
        if (wr_data[CB_STO]) begin
          if (owned_q) begin
            state    <= ST_STOP;
            sda_oe_q <= 1'b1;
          end
        end else if (wr_data[CB_STA]) begin
          state    <= ST_START;
          sda_oe_q <= 1'b0;
        end else if (state == ST_HOLD) begin
          state    <= ST_BYTE;
          bitcnt   <= '0;
          sda_oe_q <= tx_now ? ~dreg[BITS-1] : 1'b0;
          if (first_q) rd_q <= dreg[0];
        end
      end else if (q_end) begin
        unique case (state)
          ST_START: begin
            unique case (q)
              2'd0: scl_oe_q <= 1'b0;
              2'd1: sda_oe_q <= 1'b1;
              2'd2: scl_oe_q <= 1'b1;
              default: begin
                state     <= ST_HOLD;
                evt_q     <= 1'b1;
                code_q    <= owned_q ? EV_RSTART : EV_START;
                owned_q   <= 1'b1;
                first_q   <= 1'b1;
                rx_mode_q <= 1'b0;
              end
            endcase
          end
          ST_BYTE: begin
            unique case (q)
              2'd0: scl_oe_q <= 1'b0;
              2'd1: begin
                if (lost) begin
                  state    <= ST_IDLE;
                  scl_oe_q <= 1'b0;
                  sda_oe_q <= 1'b0;
                  owned_q  <= 1'b0;
                  first_q  <= 1'b0;
                  evt_q    <= 1'b1;
                  code_q   <= EV_ARB;
                end else if (bitcnt == BC_W'(BITS)) begin
                  ack_s <= sda_i;
                end
              end
              2'd2: scl_oe_q <= 1'b1;
              default: begin
                if (bitcnt < BC_W'(BITS - 1)) begin
                  bitcnt   <= bitcnt + BC_W'(1);
                  sda_oe_q <= tx_now ? ~sh_val[BITS-1] : 1'b0;
                end else if (bitcnt == BC_W'(BITS - 1)) begin
                  bitcnt   <= BC_W'(BITS);
                  sda_oe_q <= tx_now ? 1'b0 : ack_en_q;
                  if (!tx_now) dreg <= sh_val;
                end else begin
                  state    <= ST_HOLD;
                  evt_q    <= 1'b1;
                  sda_oe_q <= 1'b0;
                  first_q  <= 1'b0;
                  if (first_q) begin
                    rx_mode_q <= rd_q && !ack_s;
                    if (rd_q) code_q <= ack_s ? EV_AR_NACK : EV_AR_ACK;
                    else      code_q <= ack_s ? EV_AW_NACK : EV_AW_ACK;
                  end else if (rx_mode_q) begin
                    code_q <= ack_s ? EV_DR_NACK : EV_DR_ACK;
                  end else begin
                    code_q <= ack_s ? EV_DW_NACK : EV_DW_ACK;
                  end
                end
              end
            endcase
          end
          ST_STOP: begin
            unique case (q)
              2'd0: scl_oe_q <= 1'b0;
              2'd1: sda_oe_q <= 1'b0;
              default: begin
                state   <= ST_IDLE;
                owned_q <= 1'b0;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    status_o    = {evt_q ? code_q : EV_NONE, 3'(ps_q)};
    data_o      = dreg;
    evt_o       = evt_q;
    stop_busy_o = (state == ST_STOP);
    scl_oe_o    = scl_oe_q;
    sda_oe_o    = sda_oe_q;
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] status_o,
  input logic       evt_o,
  input logic       stop_busy_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  // R8
  frozen_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_o && !wr_en) |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));

  // R9
  stop_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
    stop_busy_o |-> !evt_o);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_busy_o) |-> (!scl_oe_o && !sda_oe_o));

  // R9
  sda_rise_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_oe_o) && !scl_oe_o && !$past(scl_oe_o) && !$past(wr_en)) |-> stop_busy_o);

  // R4
  sda_fall_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe_o) && !scl_oe_o && !$past(scl_oe_o)) |-> (!evt_o && !stop_busy_o));

  // R3
  evt_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_o) |-> (status_o[7:3] != 5'h1F && !status_o[2]));

  // R12
  disable_release_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && !wr_data[4]) |=> (!scl_oe_o && !sda_oe_o && !evt_o));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .status_o(status_o), .evt_o(evt_o), .stop_busy_o(stop_busy_o),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  localparam logic [7:0] K_CLR = 8'h01, K_STA = 8'h02, K_STO = 8'h04,
                         K_ACK = 8'h08, K_EN = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] status_o, data_o;
  logic evt_o, stop_busy_o, scl_oe_o, sda_oe_o;
  logic scl_line, sda_line;
  logic tgt_scl_low = 1'b0;
  logic tgt_sda_low;
  int   tgt_mode = 0;
  logic tgt_ack = 1'b0;
  logic [7:0] tgt_byte = 8'd0;
  int   arb_idx = 0;
  logic arm = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, tgt_idx = 0, rise_cnt = 0, last_rise = 0, per = 0;
  int start_seen = 0, stop_seen = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic [8:0] cap = '0;

  always #2 clk = ~clk;

  assign scl_line = !scl_oe_o && !tgt_scl_low;
  assign sda_line = !sda_oe_o && !tgt_sda_low;

  always_comb begin
    case (tgt_mode)
      1: tgt_sda_low = (tgt_idx == 8) && tgt_ack;
      2: tgt_sda_low = (tgt_idx < 8) && !tgt_byte[7 - (tgt_idx & 7)];
      3: tgt_sda_low = (tgt_idx == arb_idx);
      default: tgt_sda_low = 1'b0;
    endcase
  end

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status_o(status_o), .data_o(data_o), .evt_o(evt_o), .stop_busy_o(stop_busy_o),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    prev_scl <= scl_line;
    prev_sda <= sda_line;
    if (arm) tgt_idx <= 0;
    else if (prev_scl && !scl_line) tgt_idx <= tgt_idx + 1;
    if (!prev_scl && scl_line) begin
      cap       <= {cap[7:0], sda_line};
      rise_cnt  <= rise_cnt + 1;
      per       <= cyc - last_rise;
      last_rise <= cyc;
    end
    if (prev_scl && scl_line && prev_sda && !sda_line) start_seen <= start_seen + 1;
    if (prev_scl && scl_line && !prev_sda && sda_line) stop_seen <= stop_seen + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regw(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] v, input bit do_arm);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = v; arm = do_arm;
    @(negedge clk);
    wr_en = 1'b0; arm = 1'b0;
  endtask

  task automatic wait_evt(input string req);
    int n = 0;
    while (!evt_o && n < 30000) begin
      @(negedge clk);
      n++;
    end
    if (!evt_o) check(1'b0, req, 0, 1);
  endtask

  task automatic wait_stop(input string req);
    int n = 0;
    @(negedge clk);
    while (stop_busy_o && n < 30000) begin
      @(negedge clk);
      n++;
    end
    if (stop_busy_o) check(1'b0, req, 1, 0);
  endtask

  task automatic do_start(input logic [7:0] exp, input string req);
    ctl(K_EN | K_CLR | K_STA, 1'b0);
    wait_evt(req);
    check(status_o == exp, req, status_o, exp);
  endtask

  task automatic xfer(input logic [7:0] b, input int mode, input bit ack,
                      input logic [7:0] extra, input logic [7:0] exp, input string req);
    if (mode != 2) regw(2'd1, b);
    tgt_mode = mode; tgt_ack = ack; tgt_byte = b;
    ctl(K_EN | K_CLR | extra, 1'b1);
    wait_evt(req);
    check(status_o == exp, req, status_o, exp);
  endtask

  task automatic do_stop(input string req);
    tgt_mode = 0;
    ctl(K_EN | K_CLR | K_STO, 1'b0);
    wait_stop(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s0, r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status_o == 8'hF8 && !evt_o, "R1 status", status_o, 8'hF8);
    check(!scl_oe_o && !sda_oe_o && data_o == 8'h00, "R1 lines/data",
          {scl_oe_o, sda_oe_o, data_o}, 0);

    regw(2'd2, 8'd2);
    regw(2'd3, 8'd0);

    // R4 start from idle
    s0 = start_seen;
    do_start(8'h08, "R4 start");
    check(start_seen == s0 + 1 && !scl_line, "R4 start on line", start_seen - s0, 1);

    // R5 address write acked, MSB first
    xfer(8'h54, 1, 1'b1, 8'h00, 8'h18, "R5 addr W ack");
    check(cap == {8'h54, 1'b0}, "R5 addr bits", cap, {8'h54, 1'b0});

    // R8 frozen while flag set
    r0 = rise_cnt;
    repeat (200) @(negedge clk);
    check(rise_cnt == r0 && !scl_line && evt_o, "R8 frozen", rise_cnt - r0, 0);

    // R6 data write ack / nack
    xfer(8'hC3, 1, 1'b1, 8'h00, 8'h28, "R6 data ack");
    check(cap == {8'hC3, 1'b0}, "R6 data bits", cap, {8'hC3, 1'b0});
    xfer(8'h3C, 1, 1'b0, 8'h00, 8'h30, "R6 data nack");

    // R4 repeated start
    s0 = start_seen;
    do_start(8'h10, "R4 rep start");
    check(start_seen == s0 + 1, "R4 rep start line", start_seen - s0, 1);

    // R5 address read acked, R7 receive
    xfer(8'h55, 1, 1'b1, 8'h00, 8'h40, "R5 addr R ack");
    xfer(8'hA5, 2, 1'b0, K_ACK, 8'h50, "R7 rx ack");
    check(data_o == 8'hA5 && cap[0] == 1'b0, "R7 rx data+ack", {data_o, cap[0]}, {8'hA5, 1'b0});
    xfer(8'h5A, 2, 1'b0, 8'h00, 8'h58, "R7 rx nack");
    check(data_o == 8'h5A && cap[0] == 1'b1, "R7 rx data+nack", {data_o, cap[0]}, {8'h5A, 1'b1});

    // R9 stop
    s0 = stop_seen;
    do_stop("R9 stop");
    check(stop_seen == s0 + 1 && !evt_o && status_o == 8'hF8, "R9 stop",
          {stop_seen - s0, status_o}, {32'd1, 8'hF8});
    check(scl_line && sda_line, "R9 released", {scl_line, sda_line}, 2'b11);

    // R5 nack codes; R9 start+stop together
    do_start(8'h08, "R5 start");
    xfer(8'h54, 1, 1'b0, 8'h00, 8'h20, "R5 addr W nack");
    do_stop("R5 stop");
    do_start(8'h08, "R5 start2");
    xfer(8'h55, 1, 1'b0, 8'h00, 8'h48, "R5 addr R nack");
    s0 = stop_seen; r0 = start_seen;
    tgt_mode = 0;
    ctl(K_EN | K_CLR | K_STA | K_STO, 1'b0);
    wait_stop("R9 sta+sto");
    repeat (100) @(negedge clk);
    check(stop_seen == s0 + 1 && start_seen == r0 && status_o == 8'hF8,
          "R9 sta+sto stop only", {stop_seen - s0, start_seen - r0}, {32'd1, 32'd0});

    // R10 arbitration loss on bit 2
    do_start(8'h08, "R10 start");
    arb_idx = 2;
    xfer(8'hFF, 3, 1'b0, 8'h00, 8'h38, "R10 arb code");
    check(!scl_oe_o && !sda_oe_o, "R10 release", {scl_oe_o, sda_oe_o}, 0);
    r0 = rise_cnt;
    repeat (100) @(negedge clk);
    check(rise_cnt == r0 && evt_o, "R10 no clocks", rise_cnt - r0, 0);
    tgt_mode = 0;
    repeat (4) @(negedge clk);
    ctl(K_EN | K_CLR, 1'b0);
    check(status_o == 8'hF8 && !evt_o, "R10 clear", status_o, 8'hF8);
    do_start(8'h08, "R10 not owned");

    // R11 target stretch
    regw(2'd1, 8'h54);
    tgt_mode = 1; tgt_ack = 1'b1;
    ctl(K_EN | K_CLR, 1'b1);
    while (tgt_idx < 3) @(negedge clk);
    tgt_scl_low = 1'b1;
    r0 = rise_cnt;
    begin
      bit stayed = 1'b1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (scl_line || rise_cnt != r0) stayed = 1'b0;
      end
      check(stayed, "R11 held low", rise_cnt - r0, 0);
    end
    tgt_scl_low = 1'b0;
    repeat (3) @(negedge clk);
    check(per >= 50, "R11 stretched period", per, 50);
    wait_evt("R11 evt");
    check(status_o == 8'h18 && cap == {8'h54, 1'b0}, "R11 byte intact", cap, {8'h54, 1'b0});
    do_stop("R11 stop");

    // R2 / R3 rate sweep
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 3; k++) begin
        int d = (k == 0) ? 0 : (k == 1) ? 1 : 5;
        int e = 16 + 2 * d * (4 ** p);
        regw(2'd2, 8'(d));
        regw(2'd3, 8'(p));
        @(negedge clk);
        check(status_o == {5'h1F, 1'b0, 2'(p)}, "R3 prescale bits", status_o, {5'h1F, 1'b0, 2'(p)});
        do_start({5'h01, 1'b0, 2'(p)}, "R2 start");
        xfer(8'h54, 1, 1'b1, 8'h00, {5'h03, 1'b0, 2'(p)}, "R2 byte");
        check(per == e, "R2 scl period", per, e);
        do_stop("R2 stop");
      end
    end

    // R12 disable
    regw(2'd2, 8'd2);
    regw(2'd3, 8'd0);
    do_start(8'h08, "R12 start");
    ctl(8'h00, 1'b0);
    check(!evt_o && !scl_oe_o && !sda_oe_o && status_o == 8'hF8, "R12 disable",
          {evt_o, scl_oe_o, sda_oe_o, status_o}, 8'hF8);
    do_start(8'h08, "R12 fresh start");
    do_stop("R12 stop");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule